// File: doc/BRIEF.md
# Serial Command and DAC Register Interface

This block is the digital front end of a mobile-radio analog controller. A host talks to it over a four-wire serial link: chip select (active low), serial clock, data in and data out. Each transaction is a 16-bit frame that begins at the first 1 seen on data in after chip select falls. That start bit is followed by a 7-bit command and then an 8-bit data byte. The command carries a 3-bit address, two power-mode bits, a shutdown bit and a load bit.

Writes land only in per-channel input buffers. There are four DAC codes: a 6-bit crystal-tuning code, two 7-bit gain codes and a 6-bit bias code. Each channel also has side bits: the forward/reverse sense flag, the converter channel select and a 2-bit power class. When the load bit is set, every output register is copied from its buffer in one step at the end of the frame. This lets a host stage several channels and then commit them together. A read command shifts the converter result, supplied on a parallel input, out on the serial output during the data byte.

The serial pins are sampled with a free-running fabric clock after a short synchronizer. Serial clock edges are detected in that clock domain.

Top module: `radio_ctl_spi`

## Requirements
- R1: While chip select is low, data-in bits sampled as 0 before the first 1 are ignored. The first 1 sampled is the start bit, and the frame's 15 payload bits follow it.
- R2: Data in is sampled on the falling serial-clock edge. Payload bit order is address bit 2, address bit 1, address bit 0, receive-enable, transmit-enable, shutdown, load, then data bits 7 down to 0.
- R3: Address 000 writes a 6-bit crystal code from data[5:0]; data[7:6] are ignored. Address 001 writes a 7-bit up-converter code from data[6:0] and the forward flag from data[7] (1 = forward). Address 010 writes a 7-bit modulator code from data[6:0] and the direct-channel select from data[7]. Address 011 writes a 6-bit bias code from data[5:0] and the power class from data[7:6] (00 = class 1, 11 = class 4).
- R4: A complete frame with load = 0 changes only the addressed input buffer. No output changes.
- R5: A complete frame with load = 1 copies every buffer to the outputs. The same frame's receive-enable, transmit-enable and shutdown bits are also copied. The addressed buffer's new value is included, and read frames load as well.
- R6: With address 111, the converter input captured when the command completes is shifted out MSB first on the eight rising serial-clock edges of the data byte. The data-out enable is high only while chip select is low.
- R7: Addresses 100, 101 and 110 change no buffer.
- R8: A load with shutdown = 0 drives the shutdown output low and the bias code output to zero, while the bias buffer keeps its value. A later load with shutdown = 1 shows the buffered code again.
- R9: After reset all codes, the forward flag, the channel select, the power class, both power-mode bits and the shutdown output are 0.
- R10: If chip select rises before the last data bit, no buffer or output changes. The next start bit after chip select falls again begins a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock used to sample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Data-out drive enable (high while selected) |
| adc_result | input | 8 | Converter result to be read out |
| xtal_code | output | 6 | Crystal-tuning DAC code |
| up_code | output | 7 | Up-converter gain DAC code |
| mod_code | output | 7 | Modulator gain DAC code |
| bias_code | output | 6 | Bias DAC code, zero while shut down |
| fwd_sense | output | 1 | 1 = forward power sense, 0 = reverse |
| direct_ch | output | 1 | 1 = converter reads the direct input |
| pwr_class | output | 2 | Power class, 00 = class 1 |
| rx_en | output | 1 | Receive-enable power-mode bit |
| tx_en | output | 1 | Transmit-enable power-mode bit |
| shdn_out | output | 1 | Shutdown logic output, low = external bias off |

## Verification
Leading zeros are sent before some start bits. A design that opened the frame on the first clock edge would shift every field by one and corrupt the code values. Frames are cut short at 12 and at 15 bits. A counter that is off by one would commit the truncated frame, and a design without an abort rule would write partial data. Codes are staged with load clear and then committed through a read frame. This exposes designs that write outputs directly, that skip the load on reads, or that load stale buffers. Full sweeps run over the 6-bit codes, the power class and all 256 converter values, and a shutdown load is followed by a re-enable. These catch a wrong field slice, a reversed shift order, and a design that clears the bias buffer instead of masking the bias output.

// File: rtl/radio_ctl_pkg.sv
package radio_ctl_pkg;
  localparam int CMD_W      = 7;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = CMD_W + DATA_W;

  typedef enum logic [2:0] {
    ADR_X  = 3'b000,
    ADR_S  = 3'b001,
    ADR_K  = 3'b010,
    ADR_G  = 3'b011,
    ADR_RD = 3'b111
  } adr_e;

  // Field order equals arrival order: address first, load last.
  typedef struct packed {
    logic [2:0] adr;
    logic       rx;
    logic       tx;
    logic       sd;
    logic       ld;
  } cmd_t;
endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 1) begin : g_one
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_many
      logic [STAGES*W-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{RST_VAL}};
        else     sr <= {sr[(STAGES-1)*W-1:0], d};
      end
      assign q = sr[STAGES*W-1 -: W];
    end
  endgenerate
endmodule

// File: rtl/rc_frame.sv
module rc_frame
  import radio_ctl_pkg::*;
#(
  parameter int ADC_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_s,
  input  logic             sclk_s,
  input  logic             din_s,
  input  logic [ADC_W-1:0] adc_in,
  output logic             frame_done,
  output cmd_t             cmd,
  output logic [DATA_W-1:0] data,
  output logic             dout,
  output logic             dout_oe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CMD_END = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CMD_N   = CNT_W'(CMD_W);

  logic              sclk_p, fall, rise;
  logic              busy, spent, rd_act, done_q, dout_q, oe_q;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  cmd_q, cmd_nx;
  logic [DATA_W-1:0] data_q;
  logic [ADC_W-1:0]  sh_q;

  assign fall   = sclk_p & ~sclk_s;
  assign rise   = ~sclk_p & sclk_s;
  assign cmd_nx = {cmd_q[CMD_W-2:0], din_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= 1'b0;
      busy   <= 1'b0;
      spent  <= 1'b0;
      rd_act <= 1'b0;
      done_q <= 1'b0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
      cnt    <= '0;
      cmd_q  <= '0;
      data_q <= '0;
      sh_q   <= '0;
    end else begin
      sclk_p <= sclk_s;
      done_q <= 1'b0;
      oe_q   <= ~cs_n_s;
      if (cs_n_s) begin
        busy   <= 1'b0;
        spent  <= 1'b0;
        rd_act <= 1'b0;
      end else if (fall) begin
        if (!busy && !spent) begin
          if (din_s) begin
            busy   <= 1'b1;
            cnt    <= '0;
            cmd_q  <= '0;
            data_q <= '0;
          end
        end else if (busy) begin
          if (cnt < CMD_N) begin
            cmd_q <= cmd_nx;
            if (cnt == CMD_END) begin
              sh_q   <= adc_in;
              rd_act <= (cmd_nx[CMD_W-1 -: 3] == ADR_RD);
            end
          end else begin
            data_q <= {data_q[DATA_W-2:0], din_s};
          end
          if (cnt == LAST) begin
            busy   <= 1'b0;
            spent  <= 1'b1;
            done_q <= 1'b1;
            rd_act <= 1'b0;
          end
          cnt <= cnt + 1'b1;
        end
      end
      if (rise && rd_act && !cs_n_s) begin
        dout_q <= sh_q[ADC_W-1];
        sh_q   <= {sh_q[ADC_W-2:0], 1'b0};
      end
    end
  end

  assign frame_done = done_q;
  assign cmd        = cmd_t'(cmd_q);
  assign data       = data_q;
  assign dout       = dout_q;
  assign dout_oe    = oe_q;

  a_r10_abort_clears: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (!busy && !done_q));
  a_r6_dout_on_rise: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(dout_q));
  a_r1_start_is_one: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(din_s && fall));
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST));
endmodule

// File: rtl/rc_regs.sv
module rc_regs
  import radio_ctl_pkg::*;
#(
  parameter int XW = 6,
  parameter int SW = 7,
  parameter int KW = 7,
  parameter int GW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] data,
  output logic [XW-1:0]     x_out,
  output logic [SW-1:0]     s_out,
  output logic [KW-1:0]     k_out,
  output logic [GW-1:0]     g_out,
  output logic              fwd_out,
  output logic              ch_out,
  output logic [1:0]        pc_out,
  output logic              rx_out,
  output logic              tx_out,
  output logic              sdg_out
);
  logic [XW-1:0] bx, bx_n;
  logic [SW-1:0] bs, bs_n;
  logic [KW-1:0] bk, bk_n;
  logic [GW-1:0] bg, bg_n;
  logic          bf, bf_n, bc, bc_n;
  logic [1:0]    bp, bp_n;

  always_comb begin
    bx_n = bx; bs_n = bs; bk_n = bk; bg_n = bg;
    bf_n = bf; bc_n = bc; bp_n = bp;
    if (done) begin
      case (adr_e'(cmd.adr))
        ADR_X: bx_n = data[XW-1:0];
        ADR_S: begin bs_n = data[SW-1:0]; bf_n = data[DATA_W-1]; end
        ADR_K: begin bk_n = data[KW-1:0]; bc_n = data[DATA_W-1]; end
        ADR_G: begin bg_n = data[GW-1:0]; bp_n = data[DATA_W-1 -: 2]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bx <= '0; bs <= '0; bk <= '0; bg <= '0;
      bf <= 1'b0; bc <= 1'b0; bp <= '0;
      x_out <= '0; s_out <= '0; k_out <= '0; g_out <= '0;
      fwd_out <= 1'b0; ch_out <= 1'b0; pc_out <= '0;
      rx_out <= 1'b0; tx_out <= 1'b0; sdg_out <= 1'b0;
    end else begin
      bx <= bx_n; bs <= bs_n; bk <= bk_n; bg <= bg_n;
      bf <= bf_n; bc <= bc_n; bp <= bp_n;
      if (done && cmd.ld) begin
        x_out   <= bx_n;
        s_out   <= bs_n;
        k_out   <= bk_n;
        g_out   <= cmd.sd ? bg_n : '0;
        fwd_out <= bf_n;
        ch_out  <= bc_n;
        pc_out  <= bp_n;
        rx_out  <= cmd.rx;
        tx_out  <= cmd.tx;
        sdg_out <= cmd.sd;
      end
    end
  end

  a_r4_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !(done && cmd.ld) |=> $stable({x_out, s_out, k_out, g_out, fwd_out,
                                   ch_out, pc_out, rx_out, tx_out, sdg_out}));
  a_r8_bias_masked: assert property (@(posedge clk) disable iff (rst)
    !sdg_out |-> (g_out == '0));
  a_r5_mode_loaded: assert property (@(posedge clk) disable iff (rst)
    (done && cmd.ld) |=> (rx_out == $past(cmd.rx) && tx_out == $past(cmd.tx)));
endmodule

// File: rtl/radio_ctl_spi.sv
module radio_ctl_spi
  import radio_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADC_W       = 8,
  parameter int XW          = 6,
  parameter int SW          = 7,
  parameter int KW          = 7,
  parameter int GW          = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_cs_n,
  input  logic             spi_sclk,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  input  logic [ADC_W-1:0] adc_result,
  output logic [XW-1:0]    xtal_code,
  output logic [SW-1:0]    up_code,
  output logic [KW-1:0]    mod_code,
  output logic [GW-1:0]    bias_code,
  output logic             fwd_sense,
  output logic             direct_ch,
  output logic [1:0]       pwr_class,
  output logic             rx_en,
  output logic             tx_en,
  output logic             shdn_out
);
  logic [2:0]        pins_s;
  logic              done;
  cmd_t              cmd;
  logic [DATA_W-1:0] data;

  rc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sclk, spi_mosi}),
    .q(pins_s)
  );

  rc_frame #(.ADC_W(ADC_W)) u_frame (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .din_s(pins_s[0]),
    .adc_in(adc_result),
    .frame_done(done), .cmd(cmd), .data(data),
    .dout(spi_miso), .dout_oe(spi_miso_oe)
  );

  rc_regs #(.XW(XW), .SW(SW), .KW(KW), .GW(GW)) u_regs (
    .clk(clk), .rst(rst),
    .done(done), .cmd(cmd), .data(data),
    .x_out(xtal_code), .s_out(up_code), .k_out(mod_code), .g_out(bias_code),
    .fwd_out(fwd_sense), .ch_out(direct_ch), .pc_out(pwr_class),
    .rx_out(rx_en), .tx_out(tx_en), .sdg_out(shdn_out)
  );
endmodule

// File: tb/tb_radio_ctl_spi.sv
`timescale 1ns/1ps
module tb_radio_ctl_spi;
  localparam int HP = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [7:0] adc = 8'h00;
  logic miso, miso_oe;
  logic [5:0] xtal, bias;
  logic [6:0] upc, modc;
  logic fwd, dch, rxe, txe, shdn;
  logic [1:0] pcls;
  int total = 0, bad = 0;
  logic [7:0] rd;
  logic oe_seen;

  always #2.5 clk = ~clk;

  radio_ctl_spi dut (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .adc_result(adc),
    .xtal_code(xtal), .up_code(upc), .mod_code(modc), .bias_code(bias),
    .fwd_sense(fwd), .direct_ch(dch), .pwr_class(pcls),
    .rx_en(rxe), .tx_en(txe), .shdn_out(shdn)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wait_half();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bit_out(input logic b, output logic s);
    @(negedge clk); mosi = b;
    wait_half();
    sclk = 1'b1;
    wait_half();
    s = miso;
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [2:0] a, input logic rx, input logic tx,
                       input logic sd, input logic ld, input logic [7:0] d,
                       input int lead, input int nbits,
                       output logic [7:0] r, output logic oe);
    logic [15:0] v;
    logic s;
    v = {1'b1, a, rx, tx, sd, ld, d};
    r = 8'h00;
    @(negedge clk); cs_n = 1'b0;
    wait_half();
    oe = miso_oe;
    for (int i = 0; i < lead; i++) bit_out(1'b0, s);
    for (int i = 0; i < nbits; i++) begin
      bit_out(v[15-i], s);
      if (i >= 8) r[15-i] = s;
    end
    wait_half();
    cs_n = 1'b1; mosi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9", "xtal", xtal, 0); chk("R9", "up", upc, 0);
    chk("R9", "mod", modc, 0);  chk("R9", "bias", bias, 0);
    chk("R9", "mode", {rxe, txe}, 0); chk("R9", "shdn", shdn, 0);
    chk("R9", "side", {fwd, dch, pcls}, 0);
    chk("R6", "oe idle", miso_oe, 0);

    // R3/R4: stage every channel with load clear
    frame(3'b000, 0, 0, 0, 0, 8'hEA, 0, 16, rd, oe_seen);
    frame(3'b001, 0, 0, 0, 0, 8'hD5, 0, 16, rd, oe_seen);
    frame(3'b010, 0, 0, 0, 0, 8'h33, 0, 16, rd, oe_seen);
    frame(3'b011, 0, 0, 0, 0, 8'hD5, 0, 16, rd, oe_seen);
    chk("R4", "outputs held", {xtal, upc, modc, bias, fwd, dch, pcls, rxe, txe, shdn}, 0);

    // R5/R6: read frame with load commits all channels
    adc = 8'h96;
    frame(3'b111, 0, 1, 1, 1, 8'h00, 0, 16, rd, oe_seen);
    chk("R6", "read data", rd, 8'h96);
    chk("R6", "oe while selected", oe_seen, 1);
    chk("R6", "oe after deselect", miso_oe, 0);
    chk("R5", "xtal", xtal, 6'h2A); chk("R5", "up", upc, 7'h55);
    chk("R5", "fwd", fwd, 1);       chk("R5", "mod", modc, 7'h33);
    chk("R5", "dch", dch, 0);       chk("R5", "bias", bias, 6'h15);
    chk("R5", "class", pcls, 2'b11);
    chk("R2", "mode rx,tx", {rxe, txe}, 2'b01);
    chk("R5", "shdn", shdn, 1);

    // R7/R8: reserved address with shutdown load
    frame(3'b100, 1, 0, 0, 1, 8'hFF, 0, 16, rd, oe_seen);
    chk("R8", "shdn low", shdn, 0);
    chk("R8", "bias masked", bias, 0);
    chk("R2", "mode rx only", {rxe, txe}, 2'b10);
    chk("R7", "xtal kept", xtal, 6'h2A);
    chk("R7", "up kept", upc, 7'h55);
    frame(3'b101, 0, 0, 1, 1, 8'h00, 0, 16, rd, oe_seen);
    frame(3'b110, 0, 0, 1, 1, 8'h00, 0, 16, rd, oe_seen);
    chk("R8", "bias restored", bias, 6'h15);
    chk("R7", "mod kept", modc, 7'h33);

    // R10: aborted frames
    frame(3'b000, 0, 0, 1, 1, 8'h11, 0, 12, rd, oe_seen);
    chk("R10", "abort at 12", xtal, 6'h2A);
    frame(3'b000, 0, 0, 1, 1, 8'h11, 0, 15, rd, oe_seen);
    chk("R10", "abort at 15", xtal, 6'h2A);
    frame(3'b001, 0, 0, 1, 1, 8'h07, 0, 16, rd, oe_seen);
    chk("R10", "next frame up", upc, 7'h07);
    chk("R10", "next frame fwd", fwd, 0);

    // R1: leading zeros before the start bit
    frame(3'b010, 0, 0, 1, 1, 8'hC1, 5, 16, rd, oe_seen);
    chk("R1", "mod after zeros", modc, 7'h41);
    chk("R1", "dch after zeros", dch, 1);

    // R3 sweep: crystal code and bias code with class
    for (int v = 0; v < 64; v++) begin
      frame(3'b000, 0, 0, 1, 1, {v[1:0], v[5:0]}, v % 3, 16, rd, oe_seen);
      chk("R3", "xtal sweep", xtal, v[5:0]);
      frame(3'b011, 0, 0, 1, 1, {v[1:0], v[5:0]}, 0, 16, rd, oe_seen);
      chk("R3", "bias sweep", bias, v[5:0]);
      chk("R3", "class sweep", pcls, v[1:0]);
    end

    // R6 sweep: every converter value, no load
    for (int v = 0; v < 256; v++) begin
      adc = v[7:0];
      frame(3'b111, 0, 0, 1, 0, 8'h00, 0, 16, rd, oe_seen);
      chk("R6", "read sweep", rd, v[7:0]);
    end
    chk("R4", "read without load held", bias, 6'h3F);
    report();
  end
endmodule